// File: doc/BRIEF.md
# Keyed Input Scrambling Wrapper

This block sits around an untrusted storage or processing unit and makes sure that unit never receives raw input values. Every word bound for the untrusted unit is scrambled with a secret key on the way in. Every word coming back is unscrambled with the same key on the way out. A hidden trigger that waits for one particular constant, such as `32'hDECAFBAD` on an address or data bus, therefore never sees that constant. The encoding and decoding logic is small enough to review by hand, and it is the only logic the system has to trust.

Two reversible encodings are offered. One is a bitwise XOR with the key. The other is addition of the key modulo 2^W, undone by subtraction. A random source stands in for a hardware RNG or physical-unclonable key and presents a candidate key at all times. On an epoch-start pulse the wrapper captures that key together with the mode selection, and both then stay fixed until the next pulse. Until the first key has been captured after reset, the wrapper refuses all input, so raw data can never leak out before a key exists. Valid/ready handshakes pass straight through the encoder. The decoder is a registered stage with its own handshake.

Top module: `obf_wrapper`

## Requirements
- R1: After reset and before the first epoch-start pulse, `in_ready`, `enc_valid` and `out_valid` are all 0, whatever `in_valid` does.
- R2: A cycle with `epoch_start`=1 captures `rnd_key` as the key and `mode_sel` as the mode (0 = XOR, 1 = additive). The captured values are used from the following cycle on.
- R3: While `epoch_start` is 0, the captured key and mode do not change, even if `rnd_key` or `mode_sel` change.
- R4: In XOR mode, `enc_data` equals `in_data ^ key`.
- R5: In additive mode, `enc_data` equals `(in_data + key) mod 2^W`.
- R6: Decoding inverts the active mode. XOR mode yields `ut_data ^ key` and additive mode yields `(ut_data - key) mod 2^W`. A word accepted from the untrusted side appears on `out_data` with `out_valid`=1 in the cycle after that transfer.
- R7: Once a key has been captured, `enc_valid` follows `in_valid` and `in_ready` follows `enc_ready` within the same cycle.
- R8: `ut_ready` is 1 when the output register is empty or `out_ready` is 1. While `out_valid`=1 and `out_ready`=0, `out_valid` stays 1 and `out_data` does not change.
- R9: With a pass-through untrusted unit, every accepted input word reappears on `out_data` unchanged and in order. This holds for 0, all-ones and the trigger constant. With a nonzero key, the trigger constant sent as input never appears on `enc_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| epoch_start | input | 1 | Pulse that captures a new key and mode |
| rnd_key | input | W | Key offered by the random source |
| mode_sel | input | 1 | Encoding choice captured with the key: 0 XOR, 1 additive |
| in_valid | input | 1 | Raw input word valid |
| in_ready | output | 1 | Wrapper accepts the raw word |
| in_data | input | W | Raw input word |
| enc_valid | output | 1 | Scrambled word valid toward the untrusted unit |
| enc_ready | input | 1 | Untrusted unit accepts the scrambled word |
| enc_data | output | W | Scrambled word toward the untrusted unit |
| ut_valid | input | 1 | Untrusted unit result valid |
| ut_ready | output | 1 | Wrapper accepts the untrusted result |
| ut_data | input | W | Scrambled result from the untrusted unit |
| out_valid | output | 1 | Decoded output valid |
| out_ready | input | 1 | Consumer accepts the decoded output |
| out_data | output | W | Decoded output word |

## Verification
The assertions check four things on every cycle: that the key captures on the pulse and holds between pulses, that input stays locked until a key exists, that the output register fills after an untrusted-side transfer, and that it holds still under back-pressure. Only the bench scenarios can show that the encodings are arithmetically correct and that a scrambled word decodes back to its original value after a trip through an external stand-in unit. They also show ordering under random output stalls, that the trigger constant is hidden from the untrusted side, and that a change of the offered key without a pulse has no effect.

// File: rtl/obf_pkg.sv
package obf_pkg;
  typedef enum logic {
    OBF_XOR = 1'b0,
    OBF_ADD = 1'b1
  } obf_mode_e;
endpackage

// File: rtl/obf_keyreg.sv
module obf_keyreg
  import obf_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         epoch_start,
  input  logic [W-1:0] rnd_key,
  input  logic         mode_sel,
  output logic [W-1:0] key_q,
  output obf_mode_e    mode_q,
  output logic         armed
);
  // named event for the checks below
  logic capture_ev;
  assign capture_ev = epoch_start;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      key_q  <= '0;
      mode_q <= OBF_XOR;
      armed  <= 1'b0;
    end else if (capture_ev) begin
      key_q  <= rnd_key;
      mode_q <= obf_mode_e'(mode_sel);
      armed  <= 1'b1;
    end
  end

  AST_KEY_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    capture_ev |=> (key_q == $past(rnd_key)) && armed); // R2
  AST_KEY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !capture_ev |=> $stable(key_q) && $stable(mode_q)); // R3
endmodule

// File: rtl/obf_codec.sv
module obf_codec
  import obf_pkg::*;
#(
  parameter int W      = 32,
  parameter bit DECODE = 1'b0
) (
  input  logic [W-1:0] data_i,
  input  logic [W-1:0] key_i,
  input  obf_mode_e    mode_i,
  output logic [W-1:0] data_o
);
  function automatic logic [W-1:0] scramble(input logic [W-1:0] d,
                                            input logic [W-1:0] k,
                                            input obf_mode_e m);
    return (m == OBF_ADD) ? (d + k) : (d ^ k);
  endfunction

  function automatic logic [W-1:0] unscramble(input logic [W-1:0] d,
                                              input logic [W-1:0] k,
                                              input obf_mode_e m);
    return (m == OBF_ADD) ? (d - k) : (d ^ k);
  endfunction

  generate
    if (DECODE) begin : g_dec
      assign data_o = unscramble(data_i, key_i, mode_i);
    end else begin : g_enc
      assign data_o = scramble(data_i, key_i, mode_i);
    end
  endgenerate
endmodule

// File: rtl/obf_outreg.sv
module obf_outreg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] in_data,
  output logic         in_ready,
  output logic         out_valid,
  output logic [W-1:0] out_data,
  input  logic         out_ready
);
  logic take_ev;
  logic stall_ev;
  assign in_ready = !out_valid || out_ready;
  assign take_ev  = in_valid && in_ready;
  assign stall_ev = out_valid && !out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_data <= in_data;
    end
  end

  AST_FILL_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    take_ev |=> out_valid); // R6
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    stall_ev |=> out_valid && $stable(out_data)); // R8
endmodule

// File: rtl/obf_wrapper.sv
module obf_wrapper
  import obf_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         epoch_start,
  input  logic [W-1:0] rnd_key,
  input  logic         mode_sel,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         enc_valid,
  input  logic         enc_ready,
  output logic [W-1:0] enc_data,
  input  logic         ut_valid,
  output logic         ut_ready,
  input  logic [W-1:0] ut_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  logic [W-1:0] key_q;
  obf_mode_e    mode_q;
  logic         armed;
  logic [W-1:0] dec_word;

  obf_keyreg #(.W(W)) u_key (
    .clk(clk), .rst_n(rst_n), .epoch_start(epoch_start),
    .rnd_key(rnd_key), .mode_sel(mode_sel),
    .key_q(key_q), .mode_q(mode_q), .armed(armed)
  );

  obf_codec #(.W(W), .DECODE(1'b0)) u_enc (
    .data_i(in_data), .key_i(key_q), .mode_i(mode_q), .data_o(enc_data)
  );

  // input is locked until a key exists
  assign enc_valid = in_valid && armed;
  assign in_ready  = enc_ready && armed;

  obf_codec #(.W(W), .DECODE(1'b1)) u_dec (
    .data_i(ut_data), .key_i(key_q), .mode_i(mode_q), .data_o(dec_word)
  );

  obf_outreg #(.W(W)) u_out (
    .clk(clk), .rst_n(rst_n),
    .in_valid(ut_valid), .in_data(dec_word), .in_ready(ut_ready),
    .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready)
  );

  AST_LOCKED_UNTIL_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> !in_ready && !enc_valid); // R1
  AST_NO_EARLY_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> !out_valid); // R1
endmodule

// File: tb/tb_obf_wrapper.sv
module tb_obf_wrapper;
  localparam int W = 32;
  localparam logic [W-1:0] TRIG = 32'hDECAFBAD;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic epoch_start = 1'b0;
  logic [W-1:0] rnd_key = '0;
  logic mode_sel = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [W-1:0] in_data = '0;
  logic enc_valid;
  logic enc_ready;
  logic [W-1:0] enc_data;
  logic ut_valid;
  logic ut_ready;
  logic [W-1:0] ut_data;
  logic out_valid;
  logic out_ready = 1'b1;
  logic [W-1:0] out_data;

  int checks = 0;
  int errors = 0;
  logic [W-1:0] exp_q[$];
  logic [W-1:0] cur_key = '0;
  logic cur_mode = 1'b0;
  bit bp = 1'b0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  obf_wrapper #(.W(W)) dut (
    .clk(clk), .rst_n(rst_n), .epoch_start(epoch_start), .rnd_key(rnd_key),
    .mode_sel(mode_sel), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .enc_valid(enc_valid), .enc_ready(enc_ready),
    .enc_data(enc_data), .ut_valid(ut_valid), .ut_ready(ut_ready),
    .ut_data(ut_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data)
  );

  // pass-through storage standing in for the untrusted unit
  logic u_v;
  logic [W-1:0] u_d;
  always @(posedge clk) begin
    if (!rst_n) begin
      u_v <= 1'b0;
      u_d <= '0;
    end else if (!u_v || ut_ready) begin
      u_v <= enc_valid;
      u_d <= enc_data;
    end
  end
  assign enc_ready = !u_v || ut_ready;
  assign ut_valid  = u_v;
  assign ut_data   = u_d;

  task automatic chk(input bit ok, input string tag, input logic [W-1:0] act,
                     input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [W-1:0] model_enc(input logic [W-1:0] v);
    if (cur_mode) return v + cur_key;
    return v ^ cur_key;
  endfunction

  task automatic new_epoch(input logic [W-1:0] k, input logic m);
    while (exp_q.size() != 0 || u_v || out_valid) @(negedge clk);
    @(negedge clk);
    rnd_key = k; mode_sel = m; epoch_start = 1'b1;
    @(negedge clk);
    epoch_start = 1'b0;
    cur_key = k; cur_mode = m;
  endtask

  task automatic send(input logic [W-1:0] v);
    @(negedge clk);
    in_valid = 1'b1; in_data = v;
    #1;
    while (!in_ready) begin @(negedge clk); #1; end
    chk(enc_valid == 1'b1, "R7 enc_valid", {31'd0, enc_valid}, 1);
    chk(in_ready == enc_ready, "R7 in_ready", {31'd0, in_ready}, {31'd0, enc_ready});
    chk(enc_data == model_enc(v), cur_mode ? "R5 add encode" : "R4 xor encode",
        enc_data, model_enc(v));
    if (v == TRIG)
      chk(enc_data != TRIG, "R9 trigger hidden", enc_data, ~TRIG);
    exp_q.push_back(v);
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  // output consumer, changes away from the sampling edge
  initial begin
    forever begin
      @(posedge clk); #2;
      out_ready = bp ? (($urandom % 3) != 0) : 1'b1;
    end
  end

  // monitor / scoreboard
  logic prev_stall = 1'b0;
  logic [W-1:0] prev_data = '0;
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (prev_stall) begin
          chk(out_valid && out_data == prev_data, "R8 stall hold", out_data, prev_data);
        end
        chk(ut_ready == (!out_valid || out_ready), "R8 ut_ready", {31'd0, ut_ready},
            {31'd0, (!out_valid || out_ready)});
        if (out_valid && out_ready) begin
          if (exp_q.size() == 0) begin
            chk(1'b0, "R9 unexpected output", out_data, '0);
          end else begin
            logic [W-1:0] e;
            e = exp_q.pop_front();
            chk(out_data == e, "R6 R9 decode round trip", out_data, e);
          end
        end
        prev_stall = out_valid && !out_ready;
        prev_data  = out_data;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: locked before the first key
    in_valid = 1'b1; in_data = TRIG;
    repeat (3) begin
      @(negedge clk); #1;
      chk(!in_ready && !enc_valid && !out_valid, "R1 locked before key",
          {29'd0, in_ready, enc_valid, out_valid}, 0);
    end
    in_valid = 1'b0;

    // R2 R4: XOR epoch
    new_epoch(32'h5A3C_9F01, 1'b0);
    send(TRIG); send(32'h0); send(32'hFFFF_FFFF);
    for (int i = 0; i < 6; i++) send($urandom);

    // R3: offered key and mode change without a pulse
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
    rnd_key = 32'h1111_2222; mode_sel = 1'b1;
    repeat (2) @(negedge clk);
    send(32'h0000_0000);   // must still encode with old key in XOR mode
    send(TRIG);

    // R2 R5: additive epoch with carry past the top bit, random stalls
    new_epoch(32'hF000_0003, 1'b1);
    bp = 1'b1;
    send(TRIG); send(32'hFFFF_FFFF); send(32'h1000_0000); send(32'h0);
    for (int i = 0; i < 20; i++) send($urandom);

    // back-to-back burst with stalls to exercise R8
    for (int i = 0; i < 10; i++) send(32'hA500_0000 + i);
    bp = 1'b0;

    // R2: another XOR epoch after additive
    new_epoch(32'h0BAD_F00D, 1'b0);
    send(TRIG); send(32'h1234_5678);

    while (exp_q.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R9 all words delivered", exp_q.size(), 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule